// File: doc/BRIEF.md
# DDR Region Security Filter

This block guards a memory space of 4 GB against non-secure accesses. It holds eight programmable address windows with 1 MB granularity, plus a rest-of-memory region that covers every megabyte that no window contains. Software programs the windows and their security flags through a bank of seventeen 32-bit registers. In every write, the upper half-word acts as a per-bit write enable for the lower half-word. Single flags can therefore be set or cleared without first reading the register.

A requester presents a byte address and a secure or non-secure attribute on the lookup port. One clock later the block returns either a grant or a deny. Out of reset a global bypass is active, so all accesses are granted until software closes the bypass. Secure accesses are always granted. A non-secure access is denied when its megabyte index falls in an enabled window. It is also denied when it lies outside every window and the rest-of-memory flag is set. A window counts as covering a megabyte when start <= index <= end, whether or not the window is enabled, so a disabled window leaves a hole in the rest-of-memory region.

Top module: `ddr_sec_filter`

## Requirements
- R1: After reset, register 16 reads 0x00000200 (bypass set) and registers 0 to 15 read 0, so every lookup is granted.
- R2: A write changes data bit k (k = 0..15) only when write-data bit k+16 is 1. With a zero mask, the register is left unchanged.
- R3: Registers 0 to 15 keep only bits [11:0] and register 16 keeps only bits [9:0]. All other read bits, including [31:16], are 0.
- R4: A write to a register index of 17 or higher changes nothing, and a read of such an index returns 0.
- R5: When register 16 bit 9 (bypass) is 1, every lookup is granted.
- R6: A lookup with the secure attribute set is always granted.
- R7: With bypass 0, a non-secure lookup is denied when address bits [31:20] satisfy start <= idx <= end for a window n whose enable bit n in register 16 is 1. Register n holds the start and register n+8 holds the end. Both bounds are inclusive, so start = end = 0 covers exactly 0x0 to 0xFFFFF.
- R8: With bypass 0 and register 16 bit 8 set, a non-secure lookup whose megabyte index lies in no window (enabled or not) is denied.
- R9: With bypass 0, a non-secure lookup that falls only in disabled windows is granted. So is one that lies outside all windows while bit 8 is 0.
- R10: The result appears on the clock edge after a valid lookup. res_valid is 1 for exactly that cycle, exactly one of res_grant and res_deny is 1 with it, and both are 0 when res_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register index for write and read |
| reg_wdata | input | 32 | [31:16] write mask, [15:0] data |
| reg_rdata | output | 32 | Read data of register reg_addr (combinational) |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Byte address of the lookup |
| lk_secure | input | 1 | 1 = secure access |
| res_valid | output | 1 | Result is present |
| res_grant | output | 1 | Access granted |
| res_deny | output | 1 | Access denied |

## Verification
A register write takes effect on the clock edge that samples it. Reads are combinational, so the bench drives on the falling edge and reads the value back half a cycle after the following edge. A lookup result is due exactly one rising edge after the request. The bench computes the expected verdict from its own register model at the moment it drives the request, then samples at the next falling edge. On the idle cycle after each result it confirms that res_valid, res_grant and res_deny have dropped.

// File: rtl/ddr_sec_pkg.sv
// Package: shared sizing constants for the DDR region security filter.
// Assumes a 32-bit byte address and 1 MB window granularity.
package ddr_sec_pkg;
    parameter int NUM_WIN  = 8;                 // programmable windows
    parameter int IDX_W    = 12;                // megabyte index width
    parameter int ADDR_W   = 32;                // byte address width
    parameter int DATA_W   = 32;                // register word width
    parameter int HALF_W   = DATA_W / 2;        // data / mask half width
    parameter int NUM_REGS = 2 * NUM_WIN + 1;   // start, end, control
    parameter int REG_AW   = $clog2(NUM_REGS);  // register index width
    parameter int CTRL_W   = NUM_WIN + 2;       // enables, rest, bypass
    parameter int REST_BIT = NUM_WIN;           // rest-of-memory enable
    parameter int BYP_BIT  = NUM_WIN + 1;       // global bypass
endpackage

// File: rtl/ddr_sec_regbank.sv
// Module: register bank holding the window bounds and the control word.
// Every write merges the low half-word under the mask in the high half-word.
// Only the implemented field bits are stored; reads return the stored bits
// zero-extended. Assumes reg_addr is stable while it is read.
module ddr_sec_regbank
    import ddr_sec_pkg::*;
#(
    parameter int N_WIN  = NUM_WIN,
    parameter int B_W    = IDX_W,
    parameter int AW     = REG_AW,
    parameter int DW     = DATA_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_wr,
    input  logic [AW-1:0]              reg_addr,
    input  logic [DW-1:0]              reg_wdata,
    output logic [DW-1:0]              reg_rdata,
    output logic [N_WIN-1:0][B_W-1:0]  win_start,
    output logic [N_WIN-1:0][B_W-1:0]  win_end,
    output logic [N_WIN+1:0]           ctrl_word
);
    localparam int HW      = DW / 2;
    localparam int CW      = N_WIN + 2;
    localparam int CTRL_IX = 2 * N_WIN;

    logic [HW-1:0] wmask;
    logic [HW-1:0] wdat;

    assign wmask = reg_wdata[DW-1:HW];
    assign wdat  = reg_wdata[HW-1:0];

    // Merge helper for a bound field: masked update of the low B_W bits.
    function automatic logic [B_W-1:0] merge_bound(input logic [B_W-1:0] old_v,
                                                   input logic [HW-1:0] m,
                                                   input logic [HW-1:0] d);
        return (old_v & ~m[B_W-1:0]) | (d[B_W-1:0] & m[B_W-1:0]);
    endfunction

    // Merge helper for the control word: masked update of the low CW bits.
    function automatic logic [CW-1:0] merge_ctrl(input logic [CW-1:0] old_v,
                                                 input logic [HW-1:0] m,
                                                 input logic [HW-1:0] d);
        return (old_v & ~m[CW-1:0]) | (d[CW-1:0] & m[CW-1:0]);
    endfunction

    // Window start bounds: one per window, index w.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_start <= '0;
        end else if (reg_wr) begin
            for (int w = 0; w < N_WIN; w++) begin
                if (reg_addr == AW'(w))
                    win_start[w] <= merge_bound(win_start[w], wmask, wdat);
            end
        end
    end

    // Window end bounds: one per window, index w + N_WIN.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_end <= '0;
        end else if (reg_wr) begin
            for (int w = 0; w < N_WIN; w++) begin
                if (reg_addr == AW'(w + N_WIN))
                    win_end[w] <= merge_bound(win_end[w], wmask, wdat);
            end
        end
    end

    // Control word: bypass set out of reset, all other flags clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_word <= CW'(1) << (CW - 1);
        end else if (reg_wr && reg_addr == AW'(CTRL_IX)) begin
            ctrl_word <= merge_ctrl(ctrl_word, wmask, wdat);
        end
    end

    // Read mux: zero-extended stored bits, zero for unused indices.
    always_comb begin
        reg_rdata = '0;
        for (int w = 0; w < N_WIN; w++) begin
            if (reg_addr == AW'(w))
                reg_rdata = DW'(win_start[w]);
            if (reg_addr == AW'(w + N_WIN))
                reg_rdata = DW'(win_end[w]);
        end
        if (reg_addr == AW'(CTRL_IX))
            reg_rdata = DW'(ctrl_word);
    end
endmodule

// File: rtl/ddr_sec_win_match.sv
// Module: parallel inclusive range compare of one megabyte index against
// every window. A window whose start exceeds its end matches nothing.
module ddr_sec_win_match
    import ddr_sec_pkg::*;
#(
    parameter int N_WIN = NUM_WIN,
    parameter int B_W   = IDX_W
) (
    input  logic [B_W-1:0]             idx,
    input  logic [N_WIN-1:0][B_W-1:0]  win_start,
    input  logic [N_WIN-1:0][B_W-1:0]  win_end,
    output logic [N_WIN-1:0]           hit
);
    // One comparator pair per window.
    for (genvar w = 0; w < N_WIN; w++) begin : g_cmp
        assign hit[w] = (idx >= win_start[w]) && (idx <= win_end[w]);
    end
endmodule

// File: rtl/ddr_sec_decide.sv
// Module: combines window hits with the control word into a verdict and
// registers it, giving a result one clock after the request.
// Assumes hit was computed from the same cycle's lookup index.
module ddr_sec_decide
    import ddr_sec_pkg::*;
#(
    parameter int N_WIN = NUM_WIN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic              lk_secure,
    input  logic [N_WIN-1:0]  hit,
    input  logic [N_WIN+1:0]  ctrl_word,
    output logic              res_valid,
    output logic              res_grant,
    output logic              res_deny
);
    localparam int R_BIT = N_WIN;
    localparam int B_BIT = N_WIN + 1;

    logic in_enabled;
    logic in_rest;
    logic deny_now;

    // Verdict logic: enabled window hit, or rest region when flagged.
    always_comb begin
        in_enabled = |(hit & ctrl_word[N_WIN-1:0]);
        in_rest    = ~(|hit) & ctrl_word[R_BIT];
        deny_now   = ~ctrl_word[B_BIT] & ~lk_secure & (in_enabled | in_rest);
    end

    // Result register: one-cycle pulse per request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_grant <= 1'b0;
            res_deny  <= 1'b0;
        end else begin
            res_valid <= lk_valid;
            res_grant <= lk_valid & ~deny_now;
            res_deny  <= lk_valid &  deny_now;
        end
    end
endmodule

// File: rtl/ddr_sec_filter.sv
// Module: top of the DDR region security filter. Ties the register bank,
// the window comparators and the verdict stage together.
// Assumes one lookup per cycle at most and a single register master.
module ddr_sec_filter
    import ddr_sec_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic               lk_valid,
    input  logic [ADDR_W-1:0]  lk_addr,
    input  logic               lk_secure,
    output logic               res_valid,
    output logic               res_grant,
    output logic               res_deny
);
    logic [NUM_WIN-1:0][IDX_W-1:0] win_start;
    logic [NUM_WIN-1:0][IDX_W-1:0] win_end;
    logic [CTRL_W-1:0]             ctrl_word;
    logic [NUM_WIN-1:0]            hit;
    logic [IDX_W-1:0]              lk_idx;

    // Megabyte index: top IDX_W address bits.
    assign lk_idx = lk_addr[ADDR_W-1 -: IDX_W];

    ddr_sec_regbank #(
        .N_WIN(NUM_WIN), .B_W(IDX_W), .AW(REG_AW), .DW(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .win_start(win_start), .win_end(win_end), .ctrl_word(ctrl_word)
    );

    ddr_sec_win_match #(
        .N_WIN(NUM_WIN), .B_W(IDX_W)
    ) u_match (
        .idx(lk_idx), .win_start(win_start), .win_end(win_end), .hit(hit)
    );

    ddr_sec_decide #(
        .N_WIN(NUM_WIN)
    ) u_decide (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_secure(lk_secure),
        .hit(hit), .ctrl_word(ctrl_word),
        .res_valid(res_valid), .res_grant(res_grant), .res_deny(res_deny)
    );
endmodule

// File: rtl/ddr_sec_filter_chk.sv
// Checker: temporal properties of the filter, bound to the top module.
module ddr_sec_filter_chk
    import ddr_sec_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic [REG_AW-1:0]  reg_addr,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic [DATA_W-1:0]  reg_rdata,
    input logic               lk_valid,
    input logic               lk_secure,
    input logic [CTRL_W-1:0]  ctrl_word,
    input logic               res_valid,
    input logic               res_grant,
    input logic               res_deny
);
    AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:HALF_W] == '0);  // R3
    AST_ZERO_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == REG_AW'(2 * NUM_WIN) && reg_wdata[DATA_W-1:HALF_W] == '0)
        |=> $stable(ctrl_word));  // R2
    AST_BYPASS_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && ctrl_word[BYP_BIT]) |=> res_grant);  // R5
    AST_SECURE_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_secure) |=> res_grant);  // R6
    AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);  // R10
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);  // R10
    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_grant ^ res_deny));  // R10
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_grant && !res_deny));  // R10
endmodule

bind ddr_sec_filter ddr_sec_filter_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
    .lk_secure(lk_secure), .ctrl_word(ctrl_word), .res_valid(res_valid),
    .res_grant(res_grant), .res_deny(res_deny)
);

// File: tb/ddr_sec_filter_tb.sv
`timescale 1ns/1ps
module ddr_sec_filter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        lk_secure = 1'b0;
    logic        res_valid, res_grant, res_deny;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] mdl [17];

    ddr_sec_filter u_dut (.*);

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    function automatic logic [31:0] mdl_read(input int ix);
        if (ix < 16) return {20'b0, mdl[ix][11:0]};
        if (ix == 16) return {22'b0, mdl[16][9:0]};
        return 32'b0;
    endfunction

    function automatic logic exp_deny(input logic [31:0] a, input logic sec);
        logic [11:0] ix = a[31:20];
        logic any_hit = 1'b0;
        logic en_hit = 1'b0;
        for (int w = 0; w < 8; w++) begin
            if (ix >= mdl[w][11:0] && ix <= mdl[w + 8][11:0]) begin
                any_hit = 1'b1;
                if (mdl[16][w]) en_hit = 1'b1;
            end
        end
        if (mdl[16][9] || sec) return 1'b0;
        return en_hit || (!any_hit && mdl[16][8]);
    endfunction

    task automatic wr(input int ix, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'(ix); reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
        if (ix <= 16) mdl[ix] = (mdl[ix] & ~v[31:16]) | (v[15:0] & v[31:16]);
    endtask

    task automatic rd_check(input int ix, input string req);
        @(negedge clk);
        reg_addr = 5'(ix);
        #1 check(req, reg_rdata, mdl_read(ix));
    endtask

    task automatic look(input logic [31:0] a, input logic sec, input string req);
        logic e;
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a; lk_secure = sec;
        e = exp_deny(a, sec);
        @(negedge clk);
        lk_valid = 1'b0;
        check(req, {29'b0, res_valid, res_grant, res_deny}, {29'b0, 1'b1, ~e, e});
        @(negedge clk);
        check("R10", {29'b0, res_valid, res_grant, res_deny}, 32'b0);
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h5EC0_0001));
        for (int i = 0; i < 17; i++) mdl[i] = '0;
        mdl[16] = 16'h0200;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state
        for (int i = 0; i < 17; i++) rd_check(i, "R1");
        look(32'h0000_0000, 1'b0, "R1");
        // Unimplemented index
        wr(20, 32'hFFFF_FFFF);
        rd_check(20, "R4");
        rd_check(16, "R4");
        rd_check(0, "R4");
        // Field width and masking
        wr(0, 32'hFFFF_ABCD);
        check("R3", mdl_read(0), 32'h0000_0BCD);
        rd_check(0, "R3");
        wr(0, 32'h000F_0000);
        check("R2", mdl_read(0), 32'h0000_0BC0);
        rd_check(0, "R2");
        wr(16, 32'h0000_FFFF);
        rd_check(16, "R2");
        wr(16, 32'hFFFF_FE00);
        rd_check(16, "R3");
        // Window 0 = MB 0 only, enabled; bypass off
        wr(0, 32'h0FFF_0000);
        wr(16, 32'h0201_0001);
        rd_check(16, "R7");
        look(32'h000F_FFFF, 1'b0, "R7");
        look(32'h0010_0000, 1'b0, "R9");
        look(32'h0000_0000, 1'b1, "R6");
        // Window 3 = MB 5..9
        wr(3, 32'h0FFF_0005);
        wr(11, 32'h0FFF_0009);
        wr(16, 32'h0008_0008);
        look(32'h0050_0000, 1'b0, "R7");
        look(32'h009F_FFFF, 1'b0, "R7");
        look(32'h00A0_0000, 1'b0, "R9");
        look(32'h004F_FFFF, 1'b0, "R9");
        // Rest of memory
        wr(16, 32'h0100_0100);
        look(32'h00A0_0000, 1'b0, "R8");
        look(32'hFFF0_0000, 1'b0, "R8");
        look(32'hFFF0_0000, 1'b1, "R6");
        wr(16, 32'h0001_0000);
        look(32'h0000_0000, 1'b0, "R9");
        // Bypass
        wr(16, 32'h0200_0200);
        look(32'h0050_0000, 1'b0, "R5");
        look(32'hFFF0_0000, 1'b0, "R5");
        wr(16, 32'h0200_0000);
        // Random phase
        for (int k = 0; k < 3000; k++) begin
            int op = $urandom_range(0, 9);
            if (op < 3) begin
                int ix = $urandom_range(0, 18);
                logic [31:0] v;
                v[31:16] = ($urandom_range(0, 3) == 0) ? 16'(($urandom)) : 16'hFFFF;
                v[15:0]  = (ix < 16) ? 16'($urandom_range(0, 31)) : 16'($urandom);
                if (ix == 16 && $urandom_range(0, 3) != 0) v[9] = 1'b0;
                wr(ix, v);
                rd_check(ix, "R2");
            end else begin
                logic [31:0] a;
                int w = $urandom_range(0, 7);
                int pick = $urandom_range(0, 4);
                logic [11:0] ix;
                case (pick)
                    0: ix = mdl[w][11:0] - 12'd1;
                    1: ix = mdl[w][11:0];
                    2: ix = mdl[w + 8][11:0];
                    3: ix = mdl[w + 8][11:0] + 12'd1;
                    default: ix = 12'($urandom_range(0, 40));
                endcase
                a = {ix, 20'($urandom)};
                look(a, ($urandom_range(0, 4) == 0), "R7");
            end
        end
        summary();
        $finish;
    end
endmodule